// File: doc/BRIEF.md
# Two-Channel Indirect Register File

This block is the register-side front end of a two-channel serial controller. Each channel has a control port and a data port, both eight bits wide, on one shared bus. Most registers take two control-port accesses. The first write loads a register pointer, and the next control-port access, whether a read or a write, reaches the register that pointer selects. After that access the pointer returns to zero. The data port always reaches the transmit and receive registers directly and never changes the pointer.

The block stores the per-channel write registers, plus an interrupt vector and a master configuration register that both channels share. It decodes the command fields of register 0 and the reset field of register 9 into single-cycle pulses. Read registers are built from status inputs and from the stored write registers. Serial shifting, CRC generation and interrupt generation are handled elsewhere. Their status arrives on input ports, and the command pulses leave on output ports.

Top module: `serial_regfile`

## Requirements
- R1: After reset both pointers are 0, every stored register (per-channel registers, vector and master configuration) is 0x00, and `masterCfg` reads 0x00.
- R2: When the pointer is 0, a control-port write loads the pointer from bits 2:0, and adds 8 when bits 5:3 equal 1 (value 0x08). A control-port access with a non-zero pointer reaches register `ptr` and then clears that channel's pointer. Reads clear it too.
- R3: In a register-0 write, bits 5:3 with a value from 2 to 7 pulse `cmdValid` with `cmdCode` equal to that value. Non-zero bits 7:6 pulse `crcValid` with `crcCode` equal to those bits. Outside such a write, all four outputs are 0.
- R4: A data-port write, or a control write to register 8, pulses `txValid` with `txData` equal to the written byte. A data-port read, or a control read of register 8, returns that channel's byte of `rxIn`.
- R5: Register 9 is shared by both channels. A write from either channel stores bits 5:0 into `masterCfg` and always stores bits 7:6 as 0.
- R6: Bits 7:6 of a register-9 write drive `chanReset` (bit 0 = channel A, bit 1 = channel B) for one cycle. Code 11 also pulses `hwReset` and clears the shared vector. Each channel that is reset gets its pointer and its stored registers cleared.
- R7: A write to register 7 goes to the alternate option register when bit 0 of the channel's register 15 is 1. Otherwise it goes to the sync register, and the option register keeps its value.
- R8: When bit 6 of a channel's alternate option register is 1, reads of registers 4, 5, 9 and 11 return write registers 4, 5, 3 and 10. When that bit is 0, these reads return 0x00.
- R9: Reads of registers 12, 13 and 15 return the written values. Reads of registers 6, 7 and 14 return 0x00.
- R10: Read register 3 returns {2'b00, intPend} on channel A and 0x00 on channel B.
- R11: Read register 2 returns the stored vector on channel A. On channel B it returns the vector with bits 3:1 replaced by `vecStat`.
- R12: Reads of registers 0, 1 and 10 return the channel's byte of `rr0In`, `rr1In` and `rr10In`. Channel A is byte 0 and channel B is byte 1. A control read with the pointer at 0 returns register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busCh | input | 1 | Channel select (0 = A, 1 = B) |
| busSel | input | 1 | 0 = control port, 1 = data port |
| busWr | input | 1 | Write strobe, one cycle per access; wins over busRd |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid in the cycle busRd is high |
| rr0In | input | 16 | Register-0 status, channel B in the upper byte |
| rr1In | input | 16 | Register-1 status per channel |
| rr10In | input | 16 | Register-10 status per channel |
| rxIn | input | 16 | Receive data per channel |
| intPend | input | 6 | Interrupt-pending bits for both channels |
| vecStat | input | 3 | Status code folded into the channel-B vector |
| cmdValid | output | 1 | Register-0 command pulse |
| cmdCode | output | 3 | Command code (2 to 7) |
| crcValid | output | 1 | CRC/underrun reset pulse |
| crcCode | output | 2 | CRC/underrun reset code |
| txValid | output | 1 | Transmit byte pulse |
| txData | output | 8 | Transmit byte |
| chanReset | output | 2 | Channel reset pulses (bit 0 = A, bit 1 = B) |
| hwReset | output | 1 | Hardware reset pulse |
| masterCfg | output | 8 | Stored shared master configuration |

## Verification
The riskiest overlap is a register-9 reset command issued from one channel in the same cycle that the other channel holds a pointer it has loaded but not yet used. The clear from the reset and that channel's own pending second step then compete for the same pointer. The bench provokes this directly: it loads a pointer on channel B, issues a channel-B reset and then a hardware reset from channel A, and then reads channel B. It judges the outcome by checking that the read returns register 0 and not the register the pointer had selected, and that channel B's stored registers read back as cleared. Random traffic that mixes pointer steps on both channels with occasional reset codes exercises the same collision many more times against the reference model.

// File: rtl/srf_pkg.sv
package srf_pkg;
  localparam int NCH = 2;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int NREG = 1 << AW;
  localparam logic [AW-1:0] ADDR_VEC = 4'd2;
  localparam logic [AW-1:0] ADDR_OPT = 4'd7;
  localparam logic [AW-1:0] ADDR_TXRX = 4'd8;
  localparam logic [AW-1:0] ADDR_MIC = 4'd9;

  typedef struct packed {
    logic regWr;
    logic rdEn;
    logic ch;
    logic [AW-1:0] addr;
    logic [NCH-1:0] chClr;
  } srf_strobe_t;
endpackage

// File: rtl/srf_ctrl.sv
module srf_ctrl
  import srf_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic busCh,
  input  logic busSel,
  input  logic busWr,
  input  logic busRd,
  input  logic [DW-1:0] busWdata,
  output srf_strobe_t stb,
  output logic cmdValid,
  output logic [2:0] cmdCode,
  output logic crcValid,
  output logic [1:0] crcCode,
  output logic txValid,
  output logic [DW-1:0] txData,
  output logic [NCH-1:0] chanReset,
  output logic hwReset
);
  logic [NCH-1:0][AW-1:0] ptr;
  logic [AW-1:0] curPtr;
  logic stepTwo, reg0Wr, wrStep, micWr;
  logic [2:0] cmdField;

  always_comb begin
    curPtr   = ptr[busCh];
    stepTwo  = !busSel && (busWr || busRd) && (curPtr != '0);
    reg0Wr   = !busSel && busWr && (curPtr == '0);
    wrStep   = stepTwo && busWr;
    cmdField = busWdata[5:3];
    micWr    = wrStep && (curPtr == ADDR_MIC);

    stb.regWr = wrStep;
    stb.rdEn  = busRd && !busWr;
    stb.ch    = busCh;
    stb.addr  = busSel ? ADDR_TXRX : curPtr;

    cmdValid  = reg0Wr && (cmdField >= 3'd2);
    cmdCode   = cmdValid ? cmdField : 3'd0;
    crcValid  = reg0Wr && (busWdata[7:6] != 2'b00);
    crcCode   = crcValid ? busWdata[7:6] : 2'b00;
    txValid   = busWr && (busSel || (stepTwo && curPtr == ADDR_TXRX));
    txData    = txValid ? busWdata : '0;
    chanReset = micWr ? busWdata[7:6] : '0;
    hwReset   = &chanReset;
    stb.chClr = chanReset;
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (!rstN) ptr[c] <= '0;
      else if (chanReset[c]) ptr[c] <= '0;
      else if (busCh == c[0]) begin
        if (reg0Wr) ptr[c] <= {cmdField == 3'd1, busWdata[2:0]};
        else if (stepTwo) ptr[c] <= '0;
      end
    end
  end

  // R2: the second step returns the pointer to zero
  a_r2_ptr_return_a: assert property (@(posedge clk) disable iff (!rstN)
    (stepTwo && !busCh) |=> (ptr[0] == '0));
  a_r2_ptr_return_b: assert property (@(posedge clk) disable iff (!rstN)
    (stepTwo && busCh) |=> (ptr[1] == '0));
  // R6: a channel reset clears that channel's pointer
  a_r6_reset_clears_ptr: assert property (@(posedge clk) disable iff (!rstN)
    chanReset[1] |=> (ptr[1] == '0));
  // R3/R4: a transmit pulse never coincides with a register-0 command
  a_r3_tx_excludes_cmd: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> !(cmdValid || crcValid));
endmodule

// File: rtl/srf_datapath.sv
module srf_datapath
  import srf_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  srf_strobe_t stb,
  input  logic [DW-1:0] wdata,
  input  logic [NCH*DW-1:0] rr0In,
  input  logic [NCH*DW-1:0] rr1In,
  input  logic [NCH*DW-1:0] rr10In,
  input  logic [NCH*DW-1:0] rxIn,
  input  logic [5:0] intPend,
  input  logic [2:0] vecStat,
  output logic [DW-1:0] rdData,
  output logic [DW-1:0] masterCfg
);
  logic [DW-1:0] vecReg, micReg;
  logic [NCH-1:0][DW-1:0] chRd;

  always_ff @(posedge clk) begin
    if (!rstN || (&stb.chClr)) vecReg <= '0;
    else if (stb.regWr && stb.addr == ADDR_VEC) vecReg <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) micReg <= '0;
    else if (stb.regWr && stb.addr == ADDR_MIC) micReg <= {2'b00, wdata[5:0]};
  end

  assign masterCfg = micReg;

  for (genvar c = 0; c < NCH; c++) begin : gChan
    logic [DW-1:0] regs [NREG];
    logic [DW-1:0] optReg;
    logic extEn, hit;
    assign extEn = optReg[6];
    assign hit   = stb.regWr && (stb.ch == c[0]);

    always_ff @(posedge clk) begin
      if (!rstN || stb.chClr[c]) begin
        for (int i = 0; i < NREG; i++) regs[i] <= '0;
        optReg <= '0;
      end else if (hit) begin
        if (stb.addr == ADDR_OPT && regs[15][0]) optReg <= wdata;
        else if (stb.addr != ADDR_VEC && stb.addr != ADDR_TXRX && stb.addr != ADDR_MIC)
          regs[stb.addr] <= wdata;
      end
    end

    always_comb begin
      case (stb.addr)
        4'd0:  chRd[c] = rr0In[c*DW +: DW];
        4'd1:  chRd[c] = rr1In[c*DW +: DW];
        4'd2:  chRd[c] = (c == 0) ? vecReg : {vecReg[7:4], vecStat, vecReg[0]};
        4'd3:  chRd[c] = (c == 0) ? {2'b00, intPend} : '0;
        4'd4:  chRd[c] = extEn ? regs[4] : '0;
        4'd5:  chRd[c] = extEn ? regs[5] : '0;
        4'd8:  chRd[c] = rxIn[c*DW +: DW];
        4'd9:  chRd[c] = extEn ? regs[3] : '0;
        4'd10: chRd[c] = rr10In[c*DW +: DW];
        4'd11: chRd[c] = extEn ? regs[10] : '0;
        4'd12, 4'd13, 4'd15: chRd[c] = regs[stb.addr];
        default: chRd[c] = '0;
      endcase
    end

    // R6: a channel reset leaves that channel's registers cleared
    a_r6_clear_regs: assert property (@(posedge clk) disable iff (!rstN)
      stb.chClr[c] |=> (regs[15] == '0 && optReg == '0));
  end

  assign rdData = stb.rdEn ? chRd[stb.ch] : '0;

  // R10: channel B never shows interrupt-pending bits
  a_r10_rr3_b_zero: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdEn && stb.ch && stb.addr == 4'd3) |-> (rdData == '0));
  // R5: the shared register never holds the reset bits
  a_r5_mic_no_reset_bits: assert property (@(posedge clk) disable iff (!rstN)
    (stb.regWr && stb.addr == ADDR_MIC) |=> (masterCfg[7:6] == 2'b00));
endmodule

// File: rtl/serial_regfile.sv
module serial_regfile
  import srf_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic busCh,
  input  logic busSel,
  input  logic busWr,
  input  logic busRd,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  input  logic [15:0] rr0In,
  input  logic [15:0] rr1In,
  input  logic [15:0] rr10In,
  input  logic [15:0] rxIn,
  input  logic [5:0] intPend,
  input  logic [2:0] vecStat,
  output logic cmdValid,
  output logic [2:0] cmdCode,
  output logic crcValid,
  output logic [1:0] crcCode,
  output logic txValid,
  output logic [7:0] txData,
  output logic [1:0] chanReset,
  output logic hwReset,
  output logic [7:0] masterCfg
);
  srf_strobe_t stb;

  srf_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .busCh(busCh), .busSel(busSel), .busWr(busWr),
    .busRd(busRd), .busWdata(busWdata), .stb(stb), .cmdValid(cmdValid),
    .cmdCode(cmdCode), .crcValid(crcValid), .crcCode(crcCode),
    .txValid(txValid), .txData(txData), .chanReset(chanReset), .hwReset(hwReset)
  );

  srf_datapath uData (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(busWdata), .rr0In(rr0In),
    .rr1In(rr1In), .rr10In(rr10In), .rxIn(rxIn), .intPend(intPend),
    .vecStat(vecStat), .rdData(busRdata), .masterCfg(masterCfg)
  );
endmodule

// File: tb/tb_serial_regfile.sv
module tb_serial_regfile;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busCh = 1'b0, busSel = 1'b0, busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [15:0] rr0In, rr1In, rr10In, rxIn;
  logic [5:0] intPend;
  logic [2:0] vecStat;
  logic cmdValid, crcValid, txValid, hwReset;
  logic [2:0] cmdCode;
  logic [1:0] crcCode, chanReset;
  logic [7:0] txData, masterCfg;

  int nRun = 0, nFail = 0;
  logic [7:0] mWr [2][16];
  logic [7:0] mOpt [2];
  logic [7:0] mVec, mMic;
  logic [3:0] mPtr [2];

  always #10 clk = ~clk;

  serial_regfile dut (
    .clk(clk), .rstN(rstN), .busCh(busCh), .busSel(busSel), .busWr(busWr),
    .busRd(busRd), .busWdata(busWdata), .busRdata(busRdata), .rr0In(rr0In),
    .rr1In(rr1In), .rr10In(rr10In), .rxIn(rxIn), .intPend(intPend),
    .vecStat(vecStat), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .crcValid(crcValid), .crcCode(crcCode), .txValid(txValid), .txData(txData),
    .chanReset(chanReset), .hwReset(hwReset), .masterCfg(masterCfg)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic randStatus();
    rr0In = 16'($urandom); rr1In = 16'($urandom); rr10In = 16'($urandom);
    rxIn = 16'($urandom); intPend = 6'($urandom); vecStat = 3'($urandom);
  endtask

  task automatic clearChan(int c);
    for (int i = 0; i < 16; i++) mWr[c][i] = 8'h00;
    mOpt[c] = 8'h00;
    mPtr[c] = 4'd0;
  endtask

  function automatic logic [7:0] expRead(int c, logic [3:0] p);
    logic ext;
    ext = mOpt[c][6];
    case (p)
      4'd0:  return rr0In[c*8 +: 8];
      4'd1:  return rr1In[c*8 +: 8];
      4'd2:  return (c == 0) ? mVec : {mVec[7:4], vecStat, mVec[0]};
      4'd3:  return (c == 0) ? {2'b00, intPend} : 8'h00;
      4'd4:  return ext ? mWr[c][4] : 8'h00;
      4'd5:  return ext ? mWr[c][5] : 8'h00;
      4'd8:  return rxIn[c*8 +: 8];
      4'd9:  return ext ? mWr[c][3] : 8'h00;
      4'd10: return rr10In[c*8 +: 8];
      4'd11: return ext ? mWr[c][10] : 8'h00;
      4'd12, 4'd13, 4'd15: return mWr[c][p];
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tagOf(logic [3:0] p);
    case (p)
      4'd0, 4'd1, 4'd10: return "R12";
      4'd2: return "R11";
      4'd3: return "R10";
      4'd4, 4'd5, 4'd9, 4'd11: return "R8";
      4'd8: return "R4";
      default: return "R9";
    endcase
  endfunction

  // event vector: cmdValid,cmdCode,crcValid,crcCode,txValid,txData,chanReset,hwReset
  task automatic access(int c, bit sel, bit wr, bit rd, logic [7:0] d,
                        output logic [7:0] rdat, output logic [18:0] evt);
    @(negedge clk);
    busCh = c[0]; busSel = sel; busWr = wr; busRd = rd; busWdata = d;
    #5;
    rdat = busRdata;
    evt = {cmdValid, cmdCode, crcValid, crcCode, txValid, txData, chanReset, hwReset};
    @(posedge clk);
    #1;
    busWr = 1'b0; busRd = 1'b0;
    randStatus();
  endtask

  task automatic ctrlWr(int c, logic [7:0] d);
    logic [7:0] rdat;
    logic [18:0] evt, exp;
    logic [3:0] p;
    string tag;
    p = mPtr[c];
    exp = '0;
    if (p == 4'd0) begin
      tag = "R3";
      mPtr[c] = {d[5:3] == 3'd1, d[2:0]};
      if (d[5:3] >= 3'd2) exp[18:15] = {1'b1, d[5:3]};
      if (d[7:6] != 2'b00) exp[14:12] = {1'b1, d[7:6]};
    end else begin
      tag = (p == 4'd7) ? "R7" : "R2";
      mPtr[c] = 4'd0;
      case (p)
        4'd2: mVec = d;
        4'd7: if (mWr[c][15][0]) mOpt[c] = d; else mWr[c][7] = d;
        4'd8: begin exp[11:3] = {1'b1, d}; tag = "R4"; end
        4'd9: begin
          tag = "R6";
          mMic = {2'b00, d[5:0]};
          exp[2:1] = d[7:6];
          exp[0] = &d[7:6];
          if (d[6]) clearChan(0);
          if (d[7]) clearChan(1);
          if (&d[7:6]) mVec = 8'h00;
        end
        default: mWr[c][p] = d;
      endcase
    end
    access(c, 1'b0, 1'b1, 1'b0, d, rdat, evt);
    chk(tag, 32'(evt), 32'(exp));
    if (p == 4'd9) chk("R5", 32'(masterCfg), 32'(mMic));
  endtask

  task automatic ctrlRd(int c);
    logic [7:0] rdat, exp;
    logic [18:0] evt;
    logic [3:0] p;
    p = mPtr[c];
    exp = expRead(c, p);
    mPtr[c] = 4'd0;
    access(c, 1'b0, 1'b0, 1'b1, 8'h00, rdat, evt);
    chk((p == 4'd0) ? "R12" : tagOf(p), 32'(rdat), 32'(exp));
  endtask

  task automatic dataWr(int c, logic [7:0] d);
    logic [7:0] rdat;
    logic [18:0] evt;
    access(c, 1'b1, 1'b1, 1'b0, d, rdat, evt);
    chk("R4", 32'(evt), 32'({1'b1, d} << 3));
  endtask

  task automatic dataRd(int c);
    logic [7:0] rdat, exp;
    logic [18:0] evt;
    exp = rxIn[c*8 +: 8];
    access(c, 1'b1, 1'b0, 1'b1, 8'h00, rdat, evt);
    chk("R4", 32'(rdat), 32'(exp));
  endtask

  task automatic point(int c, int a);
    ctrlWr(c, {2'b00, (a >= 8) ? 3'd1 : 3'd0, 3'(a)});
  endtask

  initial begin
    #(20 * 200000);
    nRun++; nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int ch, kind, a;
    logic [7:0] v;
    void'($urandom(32'd2024));
    randStatus();
    clearChan(0); clearChan(1);
    mVec = 8'h00; mMic = 8'h00;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    chk("R1", 32'(masterCfg), 32'h0);
    ctrlRd(0);
    point(1, 12); ctrlRd(1);
    point(0, 2); ctrlRd(0);

    // R7 / R8: option register selection and extended read-back
    point(0, 4); ctrlWr(0, 8'h5A);
    point(0, 3); ctrlWr(0, 8'hC3);
    point(0, 4); ctrlRd(0);
    point(0, 15); ctrlWr(0, 8'h01);
    point(0, 7); ctrlWr(0, 8'h40);
    point(0, 4); ctrlRd(0);
    point(0, 9); ctrlRd(0);
    point(0, 15); ctrlWr(0, 8'h00);
    point(0, 7); ctrlWr(0, 8'h00);
    point(0, 9); ctrlRd(0);
    point(1, 4); ctrlWr(1, 8'h77);
    point(1, 4); ctrlRd(1);
    point(0, 14); ctrlRd(0);

    // R2 / R3: command codes; read clears pointer
    ctrlWr(0, 8'hD0); ctrlWr(0, 8'h38); ctrlWr(1, 8'h40);
    point(1, 3); ctrlRd(1); ctrlRd(1);

    // R11 / R10: vector and pending bits on both channels
    point(1, 2); ctrlWr(1, 8'hA5);
    point(0, 2); ctrlRd(0); point(1, 2); ctrlRd(1);
    point(0, 3); ctrlRd(0);

    // R4: data port and register 8 through the control port
    dataWr(1, 8'h3C); dataRd(0); point(0, 8); ctrlWr(0, 8'h99);
    point(1, 8); ctrlRd(1);

    // R6: reset from A while B holds a loaded pointer, then hardware reset
    point(1, 15); ctrlWr(1, 8'h81);
    point(1, 13);
    point(0, 9); ctrlWr(0, 8'h80);
    ctrlRd(1);
    point(1, 15); ctrlRd(1);
    point(1, 12);
    point(0, 9); ctrlWr(0, 8'hC5);
    ctrlRd(1);
    point(0, 2); ctrlRd(0);

    // random traffic
    for (int n = 0; n < 800; n++) begin
      ch = int'($urandom % 2);
      kind = int'($urandom % 10);
      if (kind == 0) dataWr(ch, 8'($urandom));
      else if (kind == 1) dataRd(ch);
      else if (kind == 2) ctrlWr(ch, {2'($urandom), 3'(2 + $urandom % 6), 3'b000});
      else if (mPtr[ch] != 4'd0) ctrlRd(ch);
      else begin
        a = 1 + int'($urandom % 15);
        point(ch, a);
        if (kind < 6) begin
          v = 8'($urandom);
          if (a == 9 && ($urandom % 8) != 0) v[7:6] = 2'b00;
          ctrlWr(ch, v);
        end else ctrlRd(ch);
      end
    end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule